// File: doc/BRIEF.md
# Sealed Logic Self-Test Engine

This block runs a complete scan-based self test without any tester help. A 16-bit pseudorandom generator feeds a set of internal scan chains that wrap a small combinational core. A 16-bit multiple-input signature register folds everything that leaves the chains into one word. A sequencer sets how many shift cycles form one load window and how many capture pulses the run contains. A final unload window flushes the last captured response into the signature.

Software or a test port programs a seed, a golden signature, a pattern count and a window length, then pulses `start`. When the run ends, the block shows only the compacted signature and a pass flag. Nothing that passed through the chains is visible while the run is in progress. A diagnostic path that joins a serial input straight to a serial output exists for failure analysis. It opens only while both a request and a separate authorisation input are high.

Top module: `lbist_ctrl`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `pass`, `signature` and `diag_so` are all 0.
- R2: A `start` pulse is accepted only in the idle or finished condition. One cycle later `busy` is 1, and `done`, `pass` and `signature` are 0.
- R3: The generator loads the latched seed at the beginning of a run. A seed of 0 is replaced by 16'hACE1. Each shift cycle it steps as g <= {g[14:0], g[15]^g[14]^g[12]^g[3]}, and chain i takes g[i] as its input bit.
- R4: In each shift cycle, every chain shifts toward its top index and takes its new bit at index 0. The signature register is cleared at the start of a run and updates as s <= {s[14:0], s[15]^s[14]^s[12]^s[3]} XOR o. Bit i of o is the top bit of chain i before the shift. A window lasts `cfg_shift` cycles, and a value of 0 counts as 1.
- R5: One capture pulse follows each window except the last. There are `cfg_patterns` captures and `cfg_patterns`+1 windows. A capture sets bit j of chain i to c[i][j] XOR (c[(i+1) mod 4][j] AND c[i][(j+1) mod 8]). Chains are cleared at the start of a run.
- R6: After the final window, one compare cycle sets `done`=1 and `busy`=0, and `signature` takes the register value. `pass` is 1 exactly when that value equals the golden word. `done` appears 2+(P+1)·L+P cycles after the cycle that accepts `start`.
- R7: Once finished, `done`, `pass` and `signature` hold their values until the next `start`, whatever the other inputs do.
- R8: Seed, golden word, pattern count and window length are latched when `start` is accepted. Later changes have no effect on the run in progress.
- R9: `diag_so` equals `diag_si` from the previous cycle when `bypass_en` and `bypass_auth` were both 1 in that cycle. Otherwise it is 0.
- R10: `signature` reads 0 for the whole time `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (single-cycle pulse) |
| cfg_seed | input | 16 | Generator seed |
| cfg_golden | input | 16 | Expected signature |
| cfg_patterns | input | 8 | Number of capture pulses |
| cfg_shift | input | 6 | Shift cycles per window |
| bypass_en | input | 1 | Request for the diagnostic path |
| bypass_auth | input | 1 | Authorisation for the diagnostic path |
| diag_si | input | 1 | Diagnostic serial input |
| diag_so | output | 1 | Diagnostic serial output, gated |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, results valid |
| pass | output | 1 | Signature matched golden |
| signature | output | 16 | Final compacted signature |

## Verification
A behavioural model follows every clock with no knowledge of the design's structure. The bench runs several seeds, pattern counts and window lengths, so any wrong tap, chain order or capture term produces a different signature. A zero seed is compared with the explicit default seed, and a window length of 0 with a length of 1. These pairs separate the substitution rules from the ordinary paths. Changing the configuration in the middle of a run checks that it was latched. Gating the diagnostic path with every combination of request and authorisation separates the real gate from a path that only needs one of the two inputs.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SEED, ST_SHIFT, ST_CAPTURE, ST_COMPARE, ST_DONE
  } lbist_state_e;

  localparam logic [15:0] LBIST_DEFAULT_SEED = 16'hACE1;

  function automatic logic [15:0] poly16_step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[14] ^ v[12] ^ v[3]};
  endfunction
endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg
  import lbist_pkg::*;
#(
  parameter int NOUT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            adv,
  input  logic [15:0]     seed,
  output logic [NOUT-1:0] bits
);
  logic [15:0] gen_q;

  always_ff @(posedge clk) begin
    if (rst) gen_q <= LBIST_DEFAULT_SEED;
    else if (load) gen_q <= (seed == 16'h0) ? LBIST_DEFAULT_SEED : seed;
    else if (adv) gen_q <= poly16_step(gen_q);
  end

  assign bits = gen_q[NOUT-1:0];

  // R3: the generator never reaches the all-zero lock-up state
  p_gen_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (gen_q != 16'h0));
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr
  import lbist_pkg::*;
#(
  parameter int NIN = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           en,
  input  logic [NIN-1:0] din,
  output logic [15:0]    sig
);
  always_ff @(posedge clk) begin
    if (rst || clear) sig <= 16'h0;
    else if (en) sig <= poly16_step(sig) ^ 16'(din);
  end

  // R4: a clear leaves the register at zero
  p_misr_clear_r4: assert property (@(posedge clk) disable iff (rst)
    clear |=> (sig == 16'h0));
endmodule

// File: rtl/lbist_scan_core.sv
module lbist_scan_core #(
  parameter int NCH  = 4,
  parameter int CLEN = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           shift,
  input  logic           capture,
  input  logic [NCH-1:0] scan_in,
  output logic [NCH-1:0] scan_out
);
  logic [CLEN-1:0] chain_q [NCH];
  logic [CLEN-1:0] resp    [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_chain
    localparam int NB = (i + 1) % NCH;
    assign scan_out[i] = chain_q[i][CLEN-1];
    for (genvar j = 0; j < CLEN; j++) begin : g_bit
      localparam int RT = (j + 1) % CLEN;
      assign resp[i][j] = chain_q[i][j] ^ (chain_q[NB][j] & chain_q[i][RT]);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (rst || clear) chain_q[i] <= '0;
      else if (shift) chain_q[i] <= {chain_q[i][CLEN-2:0], scan_in[i]};
      else if (capture) chain_q[i] <= resp[i];
    end
  end

  // R5: shift and capture are never requested together
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    !(shift && capture));
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CLEN = 8,
  parameter int PCW  = 8,
  parameter int SCW  = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [15:0]    cfg_seed,
  input  logic [15:0]    cfg_golden,
  input  logic [PCW-1:0] cfg_patterns,
  input  logic [SCW-1:0] cfg_shift,
  input  logic           bypass_en,
  input  logic           bypass_auth,
  input  logic           diag_si,
  output logic           diag_so,
  output logic           busy,
  output logic           done,
  output logic           pass,
  output logic [15:0]    signature
);
  lbist_state_e   state;
  logic [15:0]    lat_seed, lat_golden;
  logic [PCW-1:0] lat_pat, pat_cnt;
  logic [SCW-1:0] lat_last, sh_cnt;
  logic [NCH-1:0] gen_bits, chain_out;
  logic [15:0]    misr_sig;
  logic           in_seed, in_shift, in_cap, idle_like;

  assign in_seed   = (state == ST_SEED);
  assign in_shift  = (state == ST_SHIFT);
  assign in_cap    = (state == ST_CAPTURE);
  assign idle_like = (state == ST_IDLE) || (state == ST_DONE);

  lbist_prpg #(.NOUT(NCH)) u_prpg (
    .clk(clk), .rst(rst), .load(in_seed), .adv(in_shift),
    .seed(lat_seed), .bits(gen_bits));

  lbist_scan_core #(.NCH(NCH), .CLEN(CLEN)) u_core (
    .clk(clk), .rst(rst), .clear(in_seed), .shift(in_shift),
    .capture(in_cap), .scan_in(gen_bits), .scan_out(chain_out));

  lbist_misr #(.NIN(NCH)) u_misr (
    .clk(clk), .rst(rst), .clear(in_seed), .en(in_shift),
    .din(chain_out), .sig(misr_sig));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      pass       <= 1'b0;
      signature  <= '0;
      lat_seed   <= '0;
      lat_golden <= '0;
      lat_pat    <= '0;
      lat_last   <= '0;
      pat_cnt    <= '0;
      sh_cnt     <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: if (start) begin
          lat_seed   <= cfg_seed;
          lat_golden <= cfg_golden;
          lat_pat    <= cfg_patterns;
          lat_last   <= (cfg_shift == '0) ? '0 : cfg_shift - 1'b1;
          busy       <= 1'b1;
          done       <= 1'b0;
          pass       <= 1'b0;
          signature  <= '0;
          state      <= ST_SEED;
        end
        ST_SEED: begin
          pat_cnt <= '0;
          sh_cnt  <= '0;
          state   <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (sh_cnt == lat_last) begin
            sh_cnt <= '0;
            state  <= (pat_cnt == lat_pat) ? ST_COMPARE : ST_CAPTURE;
          end else begin
            sh_cnt <= sh_cnt + 1'b1;
          end
        end
        ST_CAPTURE: begin
          pat_cnt <= pat_cnt + 1'b1;
          state   <= ST_SHIFT;
        end
        ST_COMPARE: begin
          signature <= misr_sig;
          pass      <= (misr_sig == lat_golden);
          done      <= 1'b1;
          busy      <= 1'b0;
          state     <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) diag_so <= 1'b0;
    else diag_so <= (bypass_en && bypass_auth) ? diag_si : 1'b0;
  end

  // R2: an accepted start raises busy and clears done
  p_start_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (idle_like && start) |=> (busy && !done));
  // R5: every capture directly follows a shift cycle
  p_capture_after_shift_r5: assert property (@(posedge clk) disable iff (rst)
    in_cap |-> ($past(state) == ST_SHIFT));
  // R6: finished and running are exclusive
  p_done_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R7: results are frozen until a new start
  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && !start) |=> (done && $stable(signature) && $stable(pass)));
  // R9: without both gate inputs the diagnostic output stays low
  p_bypass_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !(bypass_en && bypass_auth) |=> !diag_so);
  // R10: no signature is visible while running
  p_sig_hidden_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (signature == '0));
endmodule

// File: tb/tb_lbist_ctrl.sv
module tb_lbist_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [15:0] cfg_seed = '0, cfg_golden = '0;
  logic [7:0]  cfg_patterns = '0;
  logic [5:0]  cfg_shift = '0;
  logic bypass_en = 1'b0, bypass_auth = 1'b0, diag_si = 1'b0;
  logic diag_so, busy, done, pass;
  logic [15:0] signature;

  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  lbist_ctrl dut (.*);

  // behavioural reference
  int m_phase = 0;             // 0 idle 1 seed 2 shift 3 capture 4 compare 5 done
  bit [15:0] m_gen = 16'hACE1, m_sig = 0, k_seed, k_gold;
  bit m_ch [4][8];
  int k_pat, k_len, m_sh, m_pc;
  bit e_busy = 0, e_done = 0, e_pass = 0, e_so = 0;
  bit [15:0] e_sig = 0;

  function automatic bit [15:0] rot(bit [15:0] v);
    return {v[14:0], v[15] ^ v[14] ^ v[12] ^ v[3]};
  endfunction

  task automatic model_tick();
    bit [15:0] outs;
    bit tmp [4][8];
    e_so = bypass_en && bypass_auth && diag_si;
    if (rst) begin
      m_phase = 0; e_busy = 0; e_done = 0; e_pass = 0; e_sig = 0; e_so = 0;
      return;
    end
    case (m_phase)
      0, 5: if (start) begin
        k_seed = cfg_seed; k_gold = cfg_golden; k_pat = cfg_patterns;
        k_len = (cfg_shift == 0) ? 1 : int'(cfg_shift);
        e_busy = 1; e_done = 0; e_pass = 0; e_sig = 0; m_phase = 1;
      end
      1: begin
        m_gen = (k_seed == 0) ? 16'hACE1 : k_seed;
        m_sig = 0; m_sh = 0; m_pc = 0;
        foreach (m_ch[i, j]) m_ch[i][j] = 0;
        m_phase = 2;
      end
      2: begin
        outs = 0;
        for (int i = 0; i < 4; i++) outs[i] = m_ch[i][7];
        m_sig = rot(m_sig) ^ outs;
        for (int i = 0; i < 4; i++) begin
          for (int j = 7; j > 0; j--) m_ch[i][j] = m_ch[i][j-1];
          m_ch[i][0] = m_gen[i];
        end
        m_gen = rot(m_gen);
        m_sh++;
        if (m_sh == k_len) begin
          m_sh = 0;
          m_phase = (m_pc == k_pat) ? 4 : 3;
        end
      end
      3: begin
        foreach (m_ch[i, j])
          tmp[i][j] = m_ch[i][j] ^ (m_ch[(i+1)%4][j] & m_ch[i][(j+1)%8]);
        m_ch = tmp;
        m_pc++;
        m_phase = 2;
      end
      4: begin
        e_sig = m_sig; e_pass = (m_sig == k_gold);
        e_done = 1; e_busy = 0; m_phase = 5;
      end
      default: m_phase = 0;
    endcase
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one clock: inputs stay stable over the edge, compare away from it
  task automatic step();
    @(posedge clk);
    model_tick();
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      chk(0, "R6", "watchdog", cyc, 0);
      finish_run();
    end
    chk(busy == e_busy, "R2", "busy", busy, e_busy);
    chk(done == e_done, "R6", "done", done, e_done);
    chk(pass == e_pass, "R6", "pass", pass, e_pass);
    chk(signature == e_sig, "R3 R4 R5 R10", "signature", signature, e_sig);
    chk(diag_so == e_so, "R9", "diag_so", diag_so, e_so);
  endtask

  // run to completion; returns the number of edges after the start edge
  task automatic run(input bit [15:0] sd, input bit [15:0] gd,
                     input int np, input int sl, output int edges);
    cfg_seed = sd; cfg_golden = gd; cfg_patterns = 8'(np); cfg_shift = 6'(sl);
    start = 1; step(); start = 0;
    edges = 0;
    while (!done && edges < 5000) begin step(); edges++; end
  endtask

  initial begin
    #(20ns * 190000);
    chk(0, "R6", "watchdog timer", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    bit [15:0] s_a, s_b;
    @(negedge clk);
    step(); step();
    rst = 0;
    step();
    // R1 reset state
    chk(!busy && !done && !pass && signature == 0 && !diag_so, "R1", "reset outputs",
        {busy, done, pass, diag_so}, 0);

    // R6 timing and basic run
    run(16'h1234, 16'h0000, 3, 8, n);
    chk(n == 2 + 4*8 + 3, "R6", "done latency", n, 2 + 4*8 + 3);
    s_a = signature;
    // R6 matching golden gives pass
    run(16'h1234, s_a, 3, 8, n);
    chk(pass == 1'b1, "R6", "pass on match", pass, 1);

    // R3 zero seed equals default seed
    run(16'h0000, 16'h0, 5, 6, n);
    s_a = signature;
    run(16'hACE1, 16'h0, 5, 6, n);
    chk(signature == s_a, "R3", "zero seed substitution", signature, s_a);

    // R4 window of 0 behaves as 1; R5 zero patterns: single window
    run(16'hBEEF, 16'h0, 4, 0, n);
    s_a = signature;
    chk(n == 2 + 5*1 + 4, "R4", "zero window latency", n, 2 + 5 + 4);
    run(16'hBEEF, 16'h0, 4, 1, n);
    chk(signature == s_a, "R4", "zero window equals one", signature, s_a);
    run(16'h5A5A, 16'h0, 0, 10, n);
    chk(n == 2 + 10, "R5", "no-capture run latency", n, 12);

    // R8 configuration changes mid-run are ignored
    run(16'h0F0F, 16'h0, 6, 12, n);
    s_a = signature;
    cfg_seed = 16'h0F0F; cfg_golden = s_a; cfg_patterns = 6; cfg_shift = 12;
    start = 1; step(); start = 0;
    cfg_seed = 16'h7777; cfg_golden = 16'h1111; cfg_patterns = 1; cfg_shift = 3;
    for (int i = 0; i < 200 && !done; i++) step();
    chk(signature == s_a && pass, "R8", "latched configuration", signature, s_a);

    // R7 hold in done while inputs move
    s_b = signature;
    for (int i = 0; i < 20; i++) begin
      cfg_seed = 16'(i * 977); cfg_golden = 16'(i); diag_si = i[0];
      step();
    end
    chk(done && pass && signature == s_b, "R7", "results held", signature, s_b);

    // R2 start from done restarts, longer run
    run(16'hC0DE, 16'h0, 20, 40, n);
    chk(n == 2 + 21*40 + 20, "R2", "restart from done", n, 2 + 21*40 + 20);

    // R9 diagnostic gate, all combinations
    for (int g = 0; g < 4; g++) begin
      bypass_en = g[0]; bypass_auth = g[1];
      for (int i = 0; i < 8; i++) begin
        diag_si = (i % 3) != 0;
        step();
      end
    end
    bypass_en = 1; bypass_auth = 1; diag_si = 1; step();
    chk(diag_so == 1'b1, "R9", "authorised path", diag_so, 1);
    bypass_auth = 0; step();
    chk(diag_so == 1'b0, "R9", "blocked path", diag_so, 0);
    bypass_en = 0;

    // R10 signature hidden during a run with the path open
    bypass_en = 1; bypass_auth = 1;
    cfg_seed = 16'h4321; cfg_patterns = 2; cfg_shift = 5;
    start = 1; step(); start = 0;
    step(); step();
    chk(busy && signature == 0, "R10", "hidden while busy", signature, 0);
    for (int i = 0; i < 100 && !done; i++) begin diag_si = ~diag_si; step(); end
    bypass_en = 0; bypass_auth = 0;
    step();

    // R1 reset in the middle of a run
    start = 1; step(); start = 0; step(); step();
    rst = 1; step(); rst = 0; step();
    chk(!busy && !done && signature == 0, "R1", "reset mid-run", {busy, done}, 0);

    finish_run();
  end
endmodule